// File: doc/BRIEF.md
# Boot-Time Page Remap and Boot PROM Gate

This block controls the memory map of an 8-bit CPU board that starts from a small on-board boot PROM and later gives the whole 64K address space to RAM. After reset, the top four address bits seen by the system are forced toward a configured 4K jump page, so the first fetches land in the PROM instead of page 0. Reads that hit the configured PROM page select the PROM and isolate the system data buffer, so that only the PROM's data reaches the CPU.

Software removes the boot machinery in two steps. An I/O read from port FF ends the address jump. An I/O write to port FF then takes the PROM out of the map for good, which leaves the buffer enabled. Both steps are undone only by the next reset. The upper address nibble is held by a latch that is open while memory request is asserted, so that the value stays steady for dynamic-RAM timing. A separate isolate input can force the data buffer off at any time.

Top module: `boot_map_ctrl`

## Requirements
- R1: Reset (rst_n low) sets both the jump flag and the boot-enable flag. After reset, with no bus activity, prom_cs_n=1, buf_en_n=0 and buf_dir=0.
- R2: While mreq_n=0, the internal copy of addr[15:12] follows the address combinationally and is stored at each rising clock edge. While mreq_n=1, it keeps the last value stored.
- R3: While the jump flag is set, page_addr is the bitwise OR of the held nibble and the JUMP_PAGE parameter.
- R4: While the jump flag is clear, page_addr equals the held nibble.
- R5: The page match is true when page_addr equals PROM_PAGE, whatever the values of addr[11:0].
- R6: prom_cs_n=0 only when the boot-enable flag is set, rd_n=0 and the page matches. buf_en_n=1 whenever prom_cs_n=0.
- R7: A rising clock edge that samples iorq_n=0, rd_n=0 and addr[7:0]=8'hFF clears the jump flag. I/O reads of other ports, and memory reads of address FF, leave it set.
- R8: A rising clock edge that samples iorq_n=0, wr_n=0 and addr[7:0]=8'hFF clears the boot-enable flag. After that, prom_cs_n stays 1, and buf_en_n stays 0 while isolate=0, until the next reset. Writes to other ports have no effect.
- R9: buf_dir=1 (system bus toward the CPU) when rd_n=0, and buf_dir=0 (CPU toward the system bus) when rd_n=1.
- R10: isolate=1 forces buf_en_n=1 regardless of all other inputs.
- R11: A new reset sets both flags again after a teardown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low system reset; release re-arms the boot map |
| addr | input | ADDR_W | CPU address bus |
| mreq_n | input | 1 | Active-low memory request; opens the upper-address latch |
| iorq_n | input | 1 | Active-low I/O request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| isolate | input | 1 | Forces the data buffer into tristate |
| page_addr | output | PAGE_W | Remapped upper address nibble sent to the system |
| prom_cs_n | output | 1 | Active-low boot PROM chip select |
| buf_en_n | output | 1 | Active-low system data buffer enable |
| buf_dir | output | 1 | Buffer direction: 1 toward the CPU, 0 toward the system bus |

## Verification
The assertions assume that the bus strobes and the address are stable across each rising clock edge, as they are on a synchronous CPU bus. They also assume that an I/O strobe and mreq_n are never asserted together. The stimulus changes every input only on the falling edge, and it asserts either a memory cycle or an I/O cycle but never both. The port hit is therefore decided from settled values, and the held nibble changes only in cycles where mreq_n is low.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

  // Upper-nibble remap: OR in the jump page while the jump is active.
  function automatic logic [3:0] remap_nibble(input logic [3:0] held,
                                              input logic       jump_on,
                                              input logic [3:0] jump_page);
    return jump_on ? (held | jump_page) : held;
  endfunction

  // Teardown port decode: every low address bit high.
  function automatic logic port_is_top(input logic [7:0] lo);
    return &lo;
  endfunction

endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mreq_n,
  input  logic [W-1:0] nib_in,
  output logic [W-1:0] nib_out
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (!mreq_n) held_q <= nib_in;
  end

  // open while mreq_n is low, closed otherwise
  assign nib_out = mreq_n ? held_q : nib_in;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n && $past(mreq_n)) |-> $stable(nib_out));

endmodule

// File: rtl/boot_flags.sv
module boot_flags #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [PORT_W-1:0] port,
  output logic              jump_on,
  output logic              boot_on
);
  logic port_top;
  logic rd_hit;
  logic wr_hit;

  assign port_top = &port;
  assign rd_hit   = !iorq_n && !rd_n && port_top;
  assign wr_hit   = !iorq_n && !wr_n && port_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jump_on <= 1'b1;
      boot_on <= 1'b1;
    end else begin
      if (rd_hit) jump_on <= 1'b0;
      if (wr_hit) boot_on <= 1'b0;
    end
  end

  assert_jump_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> !jump_on);
  assert_jump_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !jump_on |=> !jump_on);
  assert_boot_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> !boot_on);
  assert_boot_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_on |=> !boot_on);

endmodule

// File: rtl/bus_steer.sv
module bus_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_on,
  input  logic rd_n,
  input  logic page_hit,
  input  logic isolate,
  output logic prom_cs_n,
  output logic buf_en_n,
  output logic buf_dir
);
  logic prom_read;

  assign prom_read = boot_on && !rd_n && page_hit;
  assign prom_cs_n = !prom_read;
  assign buf_en_n  = prom_read || isolate;
  assign buf_dir   = !rd_n;

  assert_prom_needs_boot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !prom_cs_n |-> (boot_on && !rd_n && page_hit));
  assert_prom_isolates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !prom_cs_n |-> buf_en_n);
  assert_isolate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    isolate |-> buf_en_n);

endmodule

// File: rtl/boot_map_ctrl.sv
module boot_map_ctrl #(
  parameter int          ADDR_W    = 16,
  parameter int          PAGE_W    = 4,
  parameter int          PORT_W    = 8,
  parameter logic [3:0]  JUMP_PAGE = 4'hE,
  parameter logic [3:0]  PROM_PAGE = 4'hE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              isolate,
  output logic [PAGE_W-1:0] page_addr,
  output logic              prom_cs_n,
  output logic              buf_en_n,
  output logic              buf_dir
);
  import boot_map_pkg::*;

  localparam int PAGE_LO = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] held_nib;
  logic              jump_on;
  logic              boot_on;
  logic              page_hit;
  logic              unused_mid;

  assign unused_mid = ^addr[PAGE_LO-1:PORT_W];

  addr_hold #(.W(PAGE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n),
    .nib_in(addr[ADDR_W-1:PAGE_LO]), .nib_out(held_nib)
  );

  boot_flags #(.PORT_W(PORT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .port(addr[PORT_W-1:0]), .jump_on(jump_on), .boot_on(boot_on)
  );

  assign page_addr = remap_nibble(held_nib, jump_on, JUMP_PAGE);
  assign page_hit  = (page_addr == PROM_PAGE);

  bus_steer u_steer (
    .clk(clk), .rst_n(rst_n), .boot_on(boot_on), .rd_n(rd_n),
    .page_hit(page_hit), .isolate(isolate),
    .prom_cs_n(prom_cs_n), .buf_en_n(buf_en_n), .buf_dir(buf_dir)
  );

  assert_jump_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    jump_on |-> ((page_addr & JUMP_PAGE) == JUMP_PAGE));
  assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !jump_on |-> (page_addr == held_nib));

endmodule

// File: tb/test_boot_map_ctrl.sv
module test_boot_map_ctrl;
  localparam logic [3:0] JP = 4'hE;
  localparam logic [3:0] PP = 4'hE;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] addr = 0;
  logic        mreq_n = 1, iorq_n = 1, rd_n = 1, wr_n = 1, isolate = 0;
  logic [3:0]  page_addr;
  logic        prom_cs_n, buf_en_n, buf_dir;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  boot_map_ctrl #(.JUMP_PAGE(JP), .PROM_PAGE(PP)) i_boot_map_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .isolate(isolate), .page_addr(page_addr),
    .prom_cs_n(prom_cs_n), .buf_en_n(buf_en_n), .buf_dir(buf_dir)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; addr = 16'h0000;
  endtask

  // memory access to nibble n; checks all outputs against the model
  task automatic mem(input logic [3:0] n, input logic rd, input logic jmp,
                     input logic boot, input string req);
    logic [3:0] ep;
    logic       ecs;
    addr = {n, 12'(n * 273 + 5)};
    mreq_n = 0; iorq_n = 1; rd_n = rd; wr_n = ~rd;
    #1;
    ep  = jmp ? (n | JP) : n;
    ecs = !(boot && !rd && ep == PP);
    chk({req, " page"}, 16'(page_addr), 16'(ep));
    chk({req, " cs"}, 16'(prom_cs_n), 16'(ecs));
    chk({req, " en"}, 16'(buf_en_n), 16'(isolate | !ecs));
    chk({"R9 dir"}, 16'(buf_dir), 16'(!rd));
    tick();
    idle();
  endtask

  task automatic io(input logic [7:0] port, input logic is_rd);
    addr = {8'h00, port}; mreq_n = 1; iorq_n = 0;
    rd_n = !is_rd; wr_n = is_rd;
    tick();
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    #1;
    chk("R1 cs idle", 16'(prom_cs_n), 16'd1);
    chk("R1 en idle", 16'(buf_en_n), 16'd0);
    chk("R1 dir idle", 16'(buf_dir), 16'd0);
    // R3 R5 R6: jump active, every nibble, reads then writes
    for (int n = 0; n < 16; n++) mem(4'(n), 1'b0, 1'b1, 1'b1, "R3 R5 R6 jump read");
    for (int n = 0; n < 16; n++) mem(4'(n), 1'b1, 1'b1, 1'b1, "R3 R6 jump write");
    // R7: non-hitting cycles keep the jump
    io(8'hFE, 1'b1);
    io(8'h7F, 1'b1);
    addr = 16'h00FF; mreq_n = 0; rd_n = 0; tick(); idle();
    mem(4'h0, 1'b0, 1'b1, 1'b1, "R7 no-hit keeps jump");
    // R7: port FF read clears the jump
    io(8'hFF, 1'b1);
    for (int n = 0; n < 16; n++) mem(4'(n), 1'b0, 1'b0, 1'b1, "R4 R7 passthrough read");
    // R2: hold while mreq_n high
    addr = 16'h3000; mreq_n = 0; rd_n = 0; tick();
    mreq_n = 1; addr = 16'h9000; #1;
    chk("R2 hold", 16'(page_addr), 16'h3);
    addr = 16'hC000; tick(); #1;
    chk("R2 hold across edge", 16'(page_addr), 16'h3);
    idle();
    // R10: isolate with PROM read and normal read
    isolate = 1;
    mem(PP, 1'b0, 1'b0, 1'b1, "R10 isolate prom");
    mem(4'h1, 1'b0, 1'b0, 1'b1, "R10 isolate ram");
    mem(4'h1, 1'b1, 1'b0, 1'b1, "R10 isolate write");
    isolate = 0;
    // R8: write to other port has no effect
    io(8'hFE, 1'b0);
    mem(PP, 1'b0, 1'b0, 1'b1, "R8 other write keeps prom");
    io(8'hFF, 1'b0);
    for (int n = 0; n < 16; n++) mem(4'(n), 1'b0, 1'b0, 1'b0, "R8 prom gone");
    io(8'hFF, 1'b1);
    mem(PP, 1'b0, 1'b0, 1'b0, "R8 stays off");
    // R11: reset re-arms
    do_reset();
    for (int n = 0; n < 16; n++) mem(4'(n), 1'b0, 1'b1, 1'b1, "R11 rearm");
    // write teardown first, jump still on (R8 independent of R7)
    io(8'hFF, 1'b0);
    mem(4'h0, 1'b0, 1'b1, 1'b0, "R8 boot off jump on");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule